// File: doc/BRIEF.md
# Shadow First-Level Translation Cache with Automatic Refill

This block is a small first-level translation cache that sits in front of a larger second-level TLB and only ever holds copies of entries that the second level also holds. It has two arrays: one for 4 KB pages and one for pages whose size is set per entry. A lookup takes a 41-bit virtual address and the current process ID. One cycle later it returns a hit flag and a 32-bit real address.

When a lookup misses, the block raises a refill request that carries the missing address. It holds that request until the second level answers. The answer is either an entry with a valid pulse or a miss pulse. A returned entry goes into the first-level array that matches the second-level array it came from. Each array picks its victims in round-robin order. No software is involved in any of this.

The first level stays consistent with the second level through selective invalidation. A notice that a second-level entry was rewritten removes the copy of that entry. A process-ID change removes every entry except the global ones, which carry translation ID 0. An access that matches several entries at once is a programming error. No exception is raised for it, and the translation it returns is undefined.

Top module: `tlb_l1_shadow`

## Requirements
- R1: While `rst` is high and in the cycle after it, `lk_done`, `lk_hit` and `rf_req` are low, and every entry is invalid, so the first lookup after reset misses.
- R2: A lookup presented with `lk_valid` at a clock edge is answered at the next edge: `lk_done` is high, and `lk_hit` and `lk_ra` are valid. `lk_hit` is never high without `lk_done`.
- R3: An entry matches when it is valid, its virtual page number equals the lookup's page number above the page-offset boundary, and its translation ID is either 0 or equal to `lk_pid`.
- R4: Size code s (0 to 8) gives a page offset of 12+2s bits. `lk_ra` takes those offset bits from the virtual address and all higher bits from the entry's real page number.
- R5: A missing lookup with no refill outstanding raises `rf_req` and latches `rf_va` and `rf_pid`. These stay unchanged until `rf_valid` or `rf_miss` arrives. Misses that occur while a request is outstanding do not alter it.
- R6: `rf_valid` installs the returned entry into the 4 KB array when `rf_src`=0, with its size forced to code 0, or into the variable-size array when `rf_src`=1. A lookup in the following cycle can then hit.
- R7: `rf_miss` ends the outstanding request and installs nothing.
- R8: Each array overwrites its slots in round-robin order, so five installs into a 4-entry array evict the first of them.
- R9: `inv_valid` removes the entries of the array named by `inv_src` whose stored second-level index equals `inv_l2idx`. The other array is untouched.
- R10: `pid_chg` removes every entry whose translation ID is non-zero and keeps the entries with translation ID 0.
- R11: An install is dropped when, in the same cycle, `pid_chg` is high and the entry's translation ID is non-zero, or `inv_valid` names the entry's array and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 41 | Lookup virtual address |
| lk_pid | input | 8 | Current process ID |
| lk_done | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Lookup hit |
| lk_ra | output | 32 | Translated real address |
| rf_req | output | 1 | Refill request outstanding |
| rf_va | output | 41 | Address of the missing lookup |
| rf_pid | output | 8 | Process ID of the missing lookup |
| rf_valid | input | 1 | Second level returns an entry |
| rf_miss | input | 1 | Second level has no entry |
| rf_src | input | 1 | Source array: 0 = 4 KB set-associative, 1 = variable-size |
| rf_tid | input | 8 | Returned translation ID |
| rf_vpn | input | 29 | Returned virtual page number (address bits 40:12) |
| rf_size | input | 4 | Returned page-size code |
| rf_rpn | input | 20 | Returned real page number (address bits 31:12) |
| rf_l2idx | input | 9 | Second-level index of the returned entry |
| inv_valid | input | 1 | Second-level entry was rewritten |
| inv_src | input | 1 | Array of the rewritten entry |
| inv_l2idx | input | 9 | Index of the rewritten entry |
| pid_chg | input | 1 | A process-ID register changed |

## Verification
The assertions take for granted that the second level pulses `rf_valid` or `rf_miss` only while `rf_req` is high. They also assume that a variable-size entry never carries a size code above 8. The bench meets the first condition by answering only after it has seen the request raised. It meets the second by using only small size codes. The undefined multi-hit case is never provoked: every installed virtual page number is distinct, or the older copy has been removed before a new one is installed.

// File: rtl/tlbl1_pkg.sv
package tlbl1_pkg;
  parameter int VA_W   = 41;
  parameter int RA_W   = 32;
  parameter int PG_SH  = 12;
  parameter int TID_W  = 8;
  parameter int SZ_W   = 4;
  parameter int L2IX_W = 9;
  parameter int MAX_SZ = 8;
  localparam int VPN_W = VA_W - PG_SH;
  localparam int RPN_W = RA_W - PG_SH;

  typedef struct packed {
    logic              vld;
    logic [TID_W-1:0]  tid;
    logic [VPN_W-1:0]  vpn;
    logic [SZ_W-1:0]   sz;
    logic [RPN_W-1:0]  rpn;
    logic [L2IX_W-1:0] l2ix;
  } tlb_ent_t;

  // ones on the page-number bits that take part in the compare
  function automatic logic [VPN_W-1:0] pg_mask(input logic [SZ_W-1:0] sz);
    logic [VPN_W-1:0] m;
    for (int i = 0; i < VPN_W; i++) m[i] = (i >= 2 * int'(sz));
    return m;
  endfunction
endpackage

// File: rtl/tlbl1_array.sv
module tlbl1_array
  import tlbl1_pkg::*;
#(
  parameter int N        = 4,
  parameter bit FIXED_4K = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [TID_W-1:0]  q_pid,
  output logic              q_hit,
  output logic [RPN_W-1:0]  q_rpn,
  input  logic              ins_en,
  input  tlb_ent_t          ins_ent,
  input  logic              inv_en,
  input  logic [L2IX_W-1:0] inv_idx,
  input  logic              pid_chg
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  tlb_ent_t         ent [N];
  logic [PTR_W-1:0] ptr;
  logic [N-1:0]     hit_vec;
  logic [VPN_W-1:0] sel_mask;
  tlb_ent_t         ins_w;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent[g].vld &&
                        (ent[g].tid == '0 || ent[g].tid == q_pid) &&
                        (((ent[g].vpn ^ q_vpn) & pg_mask(ent[g].sz)) == '0);
  end

  always_comb begin
    q_hit    = 1'b0;
    q_rpn    = '0;
    sel_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (!q_hit && hit_vec[i]) begin
        q_hit    = 1'b1;
        sel_mask = pg_mask(ent[i].sz);
        q_rpn    = (ent[i].rpn & sel_mask[RPN_W-1:0]) |
                   (q_vpn[RPN_W-1:0] & ~sel_mask[RPN_W-1:0]);
      end
    end
  end

  always_comb begin
    ins_w     = ins_ent;
    ins_w.vld = 1'b1;
    ins_w.sz  = FIXED_4K ? '0 : ins_ent.sz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ent[i].vld <= 1'b0;
      ptr <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (pid_chg && ent[i].tid != '0)       ent[i].vld <= 1'b0;
        if (inv_en && ent[i].l2ix == inv_idx)  ent[i].vld <= 1'b0;
      end
      if (ins_en) begin
        ent[ptr] <= ins_w;
        ptr      <= (ptr == PTR_W'(N - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlbl1_refill.sv
module tlbl1_refill
  import tlbl1_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VA_W-1:0]  va,
  input  logic [TID_W-1:0] pid,
  input  logic             rsp_ok,
  input  logic             rsp_none,
  output logic             busy,
  output logic [VA_W-1:0]  q_va,
  output logic [TID_W-1:0] q_pid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (rsp_ok || rsp_none) busy <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      q_va  <= va;
      q_pid <= pid;
    end
  end
endmodule

// File: rtl/tlb_l1_shadow.sv
module tlb_l1_shadow
  import tlbl1_pkg::*;
#(
  parameter int N_4K = 4,
  parameter int N_VS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [TID_W-1:0]  lk_pid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [RA_W-1:0]   lk_ra,
  output logic              rf_req,
  output logic [VA_W-1:0]   rf_va,
  output logic [TID_W-1:0]  rf_pid,
  input  logic              rf_valid,
  input  logic              rf_miss,
  input  logic              rf_src,
  input  logic [TID_W-1:0]  rf_tid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [SZ_W-1:0]   rf_size,
  input  logic [RPN_W-1:0]  rf_rpn,
  input  logic [L2IX_W-1:0] rf_l2idx,
  input  logic              inv_valid,
  input  logic              inv_src,
  input  logic [L2IX_W-1:0] inv_l2idx,
  input  logic              pid_chg
);
  logic             hit_4k, hit_vs, hit_any;
  logic [RPN_W-1:0] rpn_4k, rpn_vs;
  logic             ins_ok;
  tlb_ent_t         ins_ent;

  assign ins_ent = '{vld: 1'b1, tid: rf_tid, vpn: rf_vpn, sz: rf_size,
                     rpn: rf_rpn, l2ix: rf_l2idx};

  // drop an install that a same-cycle invalidation would have removed
  assign ins_ok = rf_req && rf_valid &&
                  !(pid_chg && rf_tid != '0) &&
                  !(inv_valid && inv_src == rf_src && inv_l2idx == rf_l2idx);

  tlbl1_array #(.N(N_4K), .FIXED_4K(1'b1)) u_a4k (
    .clk(clk), .rst(rst),
    .q_vpn(lk_va[VA_W-1:PG_SH]), .q_pid(lk_pid),
    .q_hit(hit_4k), .q_rpn(rpn_4k),
    .ins_en(ins_ok && !rf_src), .ins_ent(ins_ent),
    .inv_en(inv_valid && !inv_src), .inv_idx(inv_l2idx),
    .pid_chg(pid_chg)
  );

  tlbl1_array #(.N(N_VS), .FIXED_4K(1'b0)) u_avs (
    .clk(clk), .rst(rst),
    .q_vpn(lk_va[VA_W-1:PG_SH]), .q_pid(lk_pid),
    .q_hit(hit_vs), .q_rpn(rpn_vs),
    .ins_en(ins_ok && rf_src), .ins_ent(ins_ent),
    .inv_en(inv_valid && inv_src), .inv_idx(inv_l2idx),
    .pid_chg(pid_chg)
  );

  assign hit_any = hit_4k || hit_vs;

  tlbl1_refill u_rf (
    .clk(clk), .rst(rst),
    .start(lk_valid && !hit_any), .va(lk_va), .pid(lk_pid),
    .rsp_ok(rf_valid), .rsp_none(rf_miss),
    .busy(rf_req), .q_va(rf_va), .q_pid(rf_pid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_ra   <= '0;
    end else begin
      lk_done <= lk_valid;
      lk_hit  <= lk_valid && hit_any;
      lk_ra   <= {(hit_4k ? rpn_4k : rpn_vs), lk_va[PG_SH-1:0]};
    end
  end
endmodule

// File: rtl/tlbl1_chk.sv
module tlbl1_chk
  import tlbl1_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_done,
  input logic             lk_hit,
  input logic             rf_req,
  input logic [VA_W-1:0]  rf_va,
  input logic [TID_W-1:0] rf_pid,
  input logic             rf_valid,
  input logic             rf_miss,
  input logic             rf_src,
  input logic [SZ_W-1:0]  rf_size
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rf_req && !lk_hit && !lk_done));

  assert_answer_next_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done);

  assert_hit_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    (rf_req && !rf_valid && !rf_miss) |=> (rf_req && $stable(rf_va) && $stable(rf_pid)));

  assert_req_from_lookup_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_req) |-> $past(lk_valid));

  assert_req_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (rf_req && (rf_valid || rf_miss)) |=> !rf_req);

  assert_reply_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
    (rf_valid || rf_miss) |-> rf_req);

  assert_size_range_R4: assert property (@(posedge clk) disable iff (rst)
    (rf_valid && rf_src) |-> (int'(rf_size) <= MAX_SZ));
endmodule

bind tlb_l1_shadow tlbl1_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_done(lk_done),
  .lk_hit(lk_hit), .rf_req(rf_req), .rf_va(rf_va), .rf_pid(rf_pid),
  .rf_valid(rf_valid), .rf_miss(rf_miss), .rf_src(rf_src), .rf_size(rf_size)
);

// File: tb/sim_tlb_l1_shadow.sv
module sim_tlb_l1_shadow;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [40:0] lk_va = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_done, lk_hit, rf_req;
  logic [31:0] lk_ra;
  logic [40:0] rf_va;
  logic [7:0]  rf_pid;
  logic        rf_valid = 1'b0, rf_miss = 1'b0, rf_src = 1'b0;
  logic [7:0]  rf_tid = '0;
  logic [28:0] rf_vpn = '0;
  logic [3:0]  rf_size = '0;
  logic [19:0] rf_rpn = '0;
  logic [8:0]  rf_l2idx = '0;
  logic        inv_valid = 1'b0, inv_src = 1'b0;
  logic [8:0]  inv_l2idx = '0;
  logic        pid_chg = 1'b0;

  int  n_chk = 0, n_fail = 0;
  bit  fin = 1'b0;
  logic        g_hit, g_req;
  logic [31:0] g_ra;
  logic [40:0] g_rfva;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_l1_shadow u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_pid(lk_pid),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_ra(lk_ra),
    .rf_req(rf_req), .rf_va(rf_va), .rf_pid(rf_pid),
    .rf_valid(rf_valid), .rf_miss(rf_miss), .rf_src(rf_src), .rf_tid(rf_tid),
    .rf_vpn(rf_vpn), .rf_size(rf_size), .rf_rpn(rf_rpn), .rf_l2idx(rf_l2idx),
    .inv_valid(inv_valid), .inv_src(inv_src), .inv_l2idx(inv_l2idx),
    .pid_chg(pid_chg)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ra(input logic [19:0] rpn, input int sz,
                                         input logic [40:0] va);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = (i < 12 + 2 * sz) ? va[i] : rpn[(i >= 12) ? i - 12 : 0];
    return r;
  endfunction

  // all tasks start and end at a falling edge
  task automatic look(input logic [40:0] va, input logic [7:0] pid);
    lk_valid = 1'b1; lk_va = va; lk_pid = pid;
    @(negedge clk);
    lk_valid = 1'b0;
    g_hit = lk_hit; g_ra = lk_ra; g_req = rf_req; g_rfva = rf_va;
  endtask

  task automatic give(input bit src, input logic [7:0] tid, input logic [28:0] vpn,
                      input logic [3:0] sz, input logic [19:0] rpn, input logic [8:0] idx,
                      input bit pc, input bit iv, input bit ivs, input logic [8:0] ivx);
    rf_valid = 1'b1; rf_src = src; rf_tid = tid; rf_vpn = vpn;
    rf_size = sz; rf_rpn = rpn; rf_l2idx = idx;
    pid_chg = pc; inv_valid = iv; inv_src = ivs; inv_l2idx = ivx;
    @(negedge clk);
    rf_valid = 1'b0; pid_chg = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic clear_req();
    if (rf_req) begin
      rf_miss = 1'b1;
      @(negedge clk);
      rf_miss = 1'b0;
    end
  endtask

  task automatic pulse_inv(input bit src, input logic [8:0] idx);
    inv_valid = 1'b1; inv_src = src; inv_l2idx = idx;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic pulse_pid();
    pid_chg = 1'b1;
    @(negedge clk);
    pid_chg = 1'b0;
  endtask

  localparam logic [40:0] VA1 = 41'h0AB_CDEF_1234;
  localparam logic [40:0] VA2 = 41'h1F0_0123_0000;
  localparam logic [40:0] VA3 = 41'h033_3333_3000;
  localparam logic [19:0] RP1 = 20'hABCDE;
  localparam logic [19:0] RP2 = 20'h55550;

  task automatic t_reset();
    chk(!lk_hit && !rf_req && !lk_done, "R1 outputs in reset",
        {lk_hit, rf_req, lk_done}, 0);
    look(VA1, 8'd5);
    chk(!g_hit, "R1 first lookup misses", g_hit, 0);
    chk(g_req && g_rfva == VA1, "R5 request raised with address", g_rfva, VA1);
    chk(rf_pid == 8'd5, "R5 request pid", rf_pid, 5);
    clear_req();
    chk(!rf_req, "R7 miss reply ends request", rf_req, 0);
    look(VA1, 8'd5);
    chk(!g_hit && g_req, "R7 nothing installed", g_hit, 0);
    clear_req();
  endtask

  task automatic t_fixed();
    look(VA1, 8'd5);
    give(1'b0, 8'd5, VA1[40:12], 4'd7, RP1, 9'd3, 0, 0, 0, 0);
    chk(!rf_req, "R6 request ends on install", rf_req, 0);
    look({VA1[40:12], 12'hF0F}, 8'd5);
    chk(g_hit, "R6 hit after 4K install", g_hit, 1);
    chk(g_ra == exp_ra(RP1, 0, {VA1[40:12], 12'hF0F}), "R4 4K real address",
        g_ra, exp_ra(RP1, 0, {VA1[40:12], 12'hF0F}));
    look(VA1 ^ (41'h1 << 12), 8'd5);
    chk(!g_hit, "R6 size forced to 4K", g_hit, 0);
    clear_req();
    look(VA1, 8'd6);
    chk(!g_hit, "R3 translation ID mismatch misses", g_hit, 0);
    clear_req();
  endtask

  task automatic t_var();
    logic [40:0] va2b;
    va2b = VA2 | 41'h0_0000_FABC;
    look(VA2, 8'd9);
    give(1'b1, 8'd0, VA2[40:12], 4'd2, RP2, 9'd3, 0, 0, 0, 0);
    look(va2b, 8'd77);
    chk(g_hit, "R3 global entry hits any pid", g_hit, 1);
    chk(g_ra == exp_ra(RP2, 2, va2b), "R4 64K real address", g_ra, exp_ra(RP2, 2, va2b));
    look(VA2 ^ (41'h1 << 16), 8'd9);
    chk(!g_hit, "R3 outside page boundary misses", g_hit, 0);
    clear_req();
  endtask

  task automatic t_inv();
    pulse_inv(1'b0, 9'd3);
    look(VA1, 8'd5);
    chk(!g_hit, "R9 rewritten 4K entry removed", g_hit, 0);
    clear_req();
    look(VA2, 8'd9);
    chk(g_hit, "R9 other array untouched", g_hit, 1);
  endtask

  task automatic t_pid();
    look(VA1, 8'd5);
    give(1'b0, 8'd5, VA1[40:12], 4'd0, RP1, 9'd4, 0, 0, 0, 0);
    look(VA1, 8'd5);
    chk(g_hit, "R6 reinstall hits", g_hit, 1);
    pulse_pid();
    look(VA1, 8'd5);
    chk(!g_hit, "R10 non-global entry removed", g_hit, 0);
    clear_req();
    look(VA2, 8'd5);
    chk(g_hit, "R10 global entry kept", g_hit, 1);
  endtask

  task automatic t_rr();
    logic [40:0] base;
    base = 41'h055_0000_0000;
    for (int k = 0; k < 5; k++) begin
      look(base + (41'(k) << 12), 8'd0);
      give(1'b0, 8'd0, base[40:12] + 29'(k), 4'd0, 20'h10 + 20'(k), 9'(100 + k),
           0, 0, 0, 0);
    end
    look(base, 8'd0);
    chk(!g_hit, "R8 oldest of five evicted", g_hit, 0);
    clear_req();
    look(base + (41'h1 << 12), 8'd0);
    chk(g_hit, "R8 second of five kept", g_hit, 1);
    look(base + (41'h4 << 12), 8'd0);
    chk(g_hit && g_ra == exp_ra(20'h14, 0, base + (41'h4 << 12)), "R8 newest kept",
        g_ra, exp_ra(20'h14, 0, base + (41'h4 << 12)));
  endtask

  task automatic t_conflict();
    look(VA3, 8'd4);
    give(1'b1, 8'd4, VA3[40:12], 4'd1, 20'h777, 9'd9, 1, 0, 0, 0);
    look(VA3, 8'd4);
    chk(!g_hit, "R11 install dropped on pid change", g_hit, 0);
    give(1'b1, 8'd4, VA3[40:12], 4'd1, 20'h777, 9'd9, 0, 1, 1, 9'd9);
    look(VA3, 8'd4);
    chk(!g_hit, "R11 install dropped on matching invalidate", g_hit, 0);
    give(1'b1, 8'd0, VA3[40:12], 4'd1, 20'h777, 9'd9, 1, 0, 0, 0);
    look(VA3, 8'd4);
    chk(g_hit, "R11 global install survives pid change", g_hit, 1);
  endtask

  task automatic t_busy();
    look(41'h066_0000_1000, 8'd2);
    chk(g_req && g_rfva == 41'h066_0000_1000, "R5 first miss latched", g_rfva,
        41'h066_0000_1000);
    look(41'h077_0000_2000, 8'd3);
    chk(g_req && g_rfva == 41'h066_0000_1000 && rf_pid == 8'd2,
        "R5 later miss ignored while busy", g_rfva, 41'h066_0000_1000);
    clear_req();
    chk(!rf_req, "R7 request closed", rf_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin end
    chk(!lk_hit && !rf_req, "R1 held in reset", {lk_hit, rf_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_var();
    t_inv();
    t_pid();
    t_rr();
    t_conflict();
    t_busy();
    fin = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule